// File: doc/BRIEF.md
# Scan-Testable Logic Datapath

This block is a small register-and-logic datapath whose every flop is built as a mux-scan cell. When the scan enable is low, each flop loads the result of an internal combinational cloud computed from the flop states and a set of primary inputs. When the scan enable is high, the same flops become one serial shift register. Bits enter at the scan input pin, move one flop per clock toward the far end, and the last flop drives the scan output pin.

A test sequence shifts a pattern in with the scan enable high, captures one functional clock with the scan enable low, then shifts the captured bits out again. One gate in the cloud, an AND of the first and last flops that feeds the second flop, can be forced stuck low or stuck high through a parameter. This lets a fault-free copy and a faulty copy be compared under the same scan sequence.

Top module: `scan_datapath`

## Requirements
- R1: With `rst` high and `scan_enable` low, every flop is 0 after the next rising clock edge.
- R2: With `scan_enable` high, `rst` has no effect: the edge shifts exactly as in R3.
- R3: With `scan_enable` high, on each rising edge flop 0 (`func_out[0]`) loads `scan_in` and flop i loads flop i-1.
- R4: With `CHAIN_LEN`=3, shifting serial bits 1, 0, 1 in over three edges leaves `func_out` = 3'b101.
- R5: In a capture edge (`scan_enable` low, `rst` low), flop 1 loads the AND of flop 0 and flop `CHAIN_LEN`-1 (the fault site).
- R6: In a capture edge, flop 0 loads `pi[0]` XOR `pi[1]` XOR flop `CHAIN_LEN`-1, and each flop i for i>=2 loads `pi[i]` XOR flop i-1.
- R7: `func_out[i]` is the state of flop i, and `scan_out` equals the last flop, `func_out[CHAIN_LEN-1]`.
- R8: Parameter `FAULT` selects no fault, stuck-at-0 or stuck-at-1 on the AND output. A stuck node changes only what flop 1 captures, never the shift path.
- R9: After a capture, one shift edge moves the value captured in flop 1 into flop 2, where it appears on `scan_out` when `CHAIN_LEN`=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock shared by all flops |
| rst | input | 1 | Synchronous active-high reset, honoured only when scan_enable is low |
| scan_enable | input | 1 | 1 selects the serial shift path, 0 selects the functional inputs |
| scan_in | input | 1 | Serial input to flop 0 |
| pi | input | CHAIN_LEN | Primary inputs to the logic cloud |
| func_out | output | CHAIN_LEN | Registered flop states |
| scan_out | output | 1 | Serial output, the last flop |

## Verification
The bench builds three copies with `CHAIN_LEN`=3: one with no fault, one stuck-at-0 and one stuck-at-1, all fed the same stimulus. Running them side by side means a single shift-capture-shift sequence shows a fault-free response and both faulty responses on `scan_out`. Patterns 101 and 100 set the AND node to 1 and to 0, which covers both polarities of detection. Random mixes of shift, capture and reset edges, some with reset and scan enable high together, then exercise the cloud equations and the reset bypass.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [1:0] {
    FAULT_NONE = 2'd0,
    FAULT_SA0  = 2'd1,
    FAULT_SA1  = 2'd2
  } fault_e;
endpackage

// File: rtl/scan_cell.sv
module scan_cell (
  input  logic clk,
  input  logic rst,
  input  logic se,
  input  logic fd,
  input  logic ti,
  output logic q
);
  logic d_sel;

  assign d_sel = se ? ti : fd;

  always_ff @(posedge clk) begin
    if (rst && !se) q <= 1'b0;
    else            q <= d_sel;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    (rst && !se) |=> (q == 1'b0));  // R1
  AST_RESET_BYPASS: assert property (@(posedge clk)
    (rst && se) |=> (q == $past(ti)));  // R2
  AST_SHIFT_LOAD: assert property (@(posedge clk) disable iff (rst)
    se |=> (q == $past(ti)));  // R3
  AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (rst)
    !se |=> (q == $past(fd)));  // R5
endmodule

// File: rtl/scan_cloud.sv
module scan_cloud
  import scan_pkg::*;
#(
  parameter int     CHAIN_LEN = 3,
  parameter fault_e FAULT     = FAULT_NONE
) (
  input  logic [CHAIN_LEN-1:0] q,
  input  logic [CHAIN_LEN-1:0] pi,
  output logic [CHAIN_LEN-1:0] d
);
  localparam int LAST = CHAIN_LEN - 1;

  logic and_good;
  logic and_node;

  assign and_good = q[0] & q[LAST];

  generate
    if (FAULT == FAULT_SA0) begin : g_sa0
      assign and_node = 1'b0;
    end else if (FAULT == FAULT_SA1) begin : g_sa1
      assign and_node = 1'b1;
    end else begin : g_ok
      assign and_node = and_good;
    end
  endgenerate

  generate
    for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_fn
      if (i == 0) begin : g_first
        assign d[i] = pi[0] ^ pi[1] ^ q[LAST];
      end else if (i == 1) begin : g_site
        assign d[i] = and_node;
      end else begin : g_rest
        assign d[i] = pi[i] ^ q[i-1];
      end
    end
  endgenerate
endmodule

// File: rtl/scan_datapath.sv
module scan_datapath
  import scan_pkg::*;
#(
  parameter int     CHAIN_LEN = 3,
  parameter fault_e FAULT     = FAULT_NONE
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 scan_enable,
  input  logic                 scan_in,
  input  logic [CHAIN_LEN-1:0] pi,
  output logic [CHAIN_LEN-1:0] func_out,
  output logic                 scan_out
);
  localparam int LAST = CHAIN_LEN - 1;

  logic [CHAIN_LEN-1:0] q;
  logic [CHAIN_LEN-1:0] fd;
  logic [CHAIN_LEN-1:0] ti;

  scan_cloud #(.CHAIN_LEN(CHAIN_LEN), .FAULT(FAULT)) u_cloud (
    .q  (q),
    .pi (pi),
    .d  (fd)
  );

  assign ti = {q[LAST-1:0], scan_in};

  generate
    for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_cell
      scan_cell u_cell (
        .clk (clk),
        .rst (rst),
        .se  (scan_enable),
        .fd  (fd[i]),
        .ti  (ti[i]),
        .q   (q[i])
      );
    end
  endgenerate

  assign func_out = q;
  assign scan_out = q[LAST];

  AST_CHAIN_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    scan_enable |=> (func_out[LAST:1] == $past(func_out[LAST-1:0])));  // R3

  generate
    if (FAULT == FAULT_SA0) begin : g_chk_sa0
      AST_STUCK_LOW: assert property (@(posedge clk) disable iff (rst)
        !scan_enable |=> !func_out[1]);  // R8
    end else if (FAULT == FAULT_SA1) begin : g_chk_sa1
      AST_STUCK_HIGH: assert property (@(posedge clk) disable iff (rst)
        !scan_enable |=> func_out[1]);  // R8
    end else begin : g_chk_ok
      AST_AND_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        !scan_enable |=> (func_out[1] == ($past(func_out[0]) & $past(func_out[LAST]))));  // R5
    end
  endgenerate
endmodule

// File: tb/tb_scan_datapath.sv
module tb_scan_datapath;
  import scan_pkg::*;
  localparam int N = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, se = 1'b0, si = 1'b0;
  logic [N-1:0] pi = '0;
  logic [N-1:0] fo_n, fo_0, fo_1;
  logic so_n, so_0, so_1;
  logic [N-1:0] m_n = '0, m_0 = '0, m_1 = '0;
  int checks = 0, fails = 0;

  scan_datapath #(.CHAIN_LEN(N), .FAULT(FAULT_NONE)) dut (
    .clk(clk), .rst(rst), .scan_enable(se), .scan_in(si), .pi(pi),
    .func_out(fo_n), .scan_out(so_n));
  scan_datapath #(.CHAIN_LEN(N), .FAULT(FAULT_SA0)) dut_sa0 (
    .clk(clk), .rst(rst), .scan_enable(se), .scan_in(si), .pi(pi),
    .func_out(fo_0), .scan_out(so_0));
  scan_datapath #(.CHAIN_LEN(N), .FAULT(FAULT_SA1)) dut_sa1 (
    .clk(clk), .rst(rst), .scan_enable(se), .scan_in(si), .pi(pi),
    .func_out(fo_1), .scan_out(so_1));

  function automatic logic [N-1:0] nxt(logic [N-1:0] q, logic r, logic s,
                                       logic b, logic [N-1:0] p, fault_e f);
    logic [N-1:0] n;
    logic a;
    if (s) return {q[N-2:0], b};
    if (r) return '0;
    a = q[0] & q[N-1];
    if (f == FAULT_SA0) a = 1'b0;
    if (f == FAULT_SA1) a = 1'b1;
    for (int i = 0; i < N; i++) begin
      if (i == 0)      n[i] = p[0] ^ p[1] ^ q[N-1];
      else if (i == 1) n[i] = a;
      else             n[i] = p[i] ^ q[i-1];
    end
    return n;
  endfunction

  task automatic check(string tag, logic [N-1:0] got, logic [N-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic step(logic r, logic s, logic b, logic [N-1:0] p);
    @(negedge clk);
    rst = r; se = s; si = b; pi = p;
    m_n = nxt(m_n, r, s, b, p, FAULT_NONE);
    m_0 = nxt(m_0, r, s, b, p, FAULT_SA0);
    m_1 = nxt(m_1, r, s, b, p, FAULT_SA1);
    @(posedge clk);
    #1;
  endtask

  task automatic check_all(string tag);
    check({tag, " func_out nofault"}, fo_n, m_n);
    check({tag, " func_out sa0"}, fo_0, m_0);
    check({tag, " func_out sa1"}, fo_1, m_1);
    check("R7 scan_out last flop", {{(N-1){1'b0}}, so_n}, {{(N-1){1'b0}}, m_n[N-1]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired got=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    step(1'b1, 1'b0, 1'b1, '1);
    check_all("R1 reset");
    check("R1 reset zero", fo_n, '0);

    step(1'b1, 1'b1, 1'b1, '0);
    check_all("R2 reset ignored in shift");
    check("R2 bit shifted under reset", fo_n, 3'b001);

    step(1'b0, 1'b1, 1'b1, '0);
    check_all("R3 shift");
    step(1'b0, 1'b1, 1'b0, '0);
    check_all("R3 shift");
    step(1'b0, 1'b1, 1'b1, '0);
    check_all("R3 shift");
    check("R4 pattern 101", fo_n, 3'b101);

    step(1'b0, 1'b0, 1'b0, 3'b000);
    check_all("R5 R6 capture");
    check("R5 and captured", {2'b00, fo_n[1]}, 3'b001);
    check("R8 sa0 captured", {2'b00, fo_0[1]}, 3'b000);
    check("R8 sa1 captured", {2'b00, fo_1[1]}, 3'b001);

    step(1'b0, 1'b1, 1'b0, '0);
    check_all("R9 shift out");
    check("R9 good scan_out", {2'b00, so_n}, 3'b001);
    check("R8 R9 sa0 detected", {2'b00, so_0}, 3'b000);

    step(1'b0, 1'b1, 1'b1, '0);
    step(1'b0, 1'b1, 1'b0, '0);
    step(1'b0, 1'b1, 1'b0, '0);
    check("R3 pattern 100", fo_n, 3'b100);
    step(1'b0, 1'b0, 1'b0, 3'b000);
    check_all("R5 R6 capture and low");
    step(1'b0, 1'b1, 1'b0, '0);
    check("R9 good scan_out low", {2'b00, so_n}, 3'b000);
    check("R8 R9 sa1 detected", {2'b00, so_1}, 3'b001);

    for (int k = 0; k < 400; k++) begin
      logic r, s, b;
      logic [N-1:0] p;
      r = ($urandom % 16) == 0;
      s = $urandom % 2;
      b = $urandom % 2;
      p = N'($urandom);
      step(r, s, b, p);
      if (s)      check_all(r ? "R2 random" : "R3 random");
      else if (r) check_all("R1 random");
      else        check_all("R5 R6 R8 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule